// File: doc/BRIEF.md
# Monochrome Glyph Framebuffer Writer

This block draws one character cell into a linear true-colour framebuffer. It holds a fixed 16-pixel by 29-row glyph as packed one-bit pixels that it reads from an external glyph store. It turns every bit into a full-white or full-black pixel of three bytes and emits one byte write per clock, with the target byte address worked out as it goes. The caller supplies the framebuffer base address, the pixel position of the cell's top-left corner, the framebuffer width in pixels and a one-cycle start pulse. The block signals completion with a one-cycle pulse.

Glyph bytes are fetched through a request port. The block raises a read-valid together with a byte index, and the store returns that byte on its data input during the following cycle. The next byte is fetched while the current one is still being written, so writes run back to back from the first pixel to the last. Base, width and position are captured when the start pulse is accepted, and they do not affect the rest of the cell.

Top module: `glyph_blit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, wr_en, rd_valid and done are all low.
- R2: Glyph bytes are requested exactly once each, in ascending index order 0 to 57. Byte index = row·2 + column/8, so each row uses two bytes. Data is taken from rd_data in the cycle after the request.
- R3: Within a glyph byte, bit 7 is the leftmost pixel and bit 0 is the rightmost.
- R4: A set bit writes 0xFF to all three bytes of its pixel, and a clear bit writes 0x00 to all three.
- R5: Each pixel occupies three consecutive byte addresses, written in the order blue, green, red.
- R6: The first write goes to fb_base + (pos_x + pos_y·fb_width)·3.
- R7: The first byte of glyph row r is written at (first address) + r·fb_width·3. After the last byte of a row, the address skips (fb_width − 16)·3 bytes.
- R8: A start pulse accepted at clock edge E produces the first write in the third cycle after E. After that, wr_en is high for exactly 1392 consecutive cycles.
- R9: done is high for exactly one cycle, in the cycle that follows the last write.
- R10: A start pulse that arrives while a cell is being drawn does not restart the drawing and does not begin a second cell.
- R11: Changes to fb_base, fb_width, pos_x or pos_y after a start has been accepted do not alter any address of the cell being drawn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin drawing a cell; accepted only when idle |
| fb_base | input | ADDR_W | Framebuffer base byte address |
| pos_x | input | POS_W | Cell left edge, in pixels |
| pos_y | input | POS_W | Cell top edge, in rows |
| fb_width | input | POS_W | Framebuffer width, in pixels |
| rd_valid | output | 1 | Glyph byte request |
| rd_addr | output | PTR_W | Glyph byte index being requested |
| rd_data | input | 8 | Glyph byte, valid in the cycle after rd_valid |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | ADDR_W | Byte write address |
| wr_data | output | 8 | Byte write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
If the column or channel counter slips, the data pattern shifts against the address pattern. This shows as a wrong byte value or a wrong address within the same pixel or row. The bench compares every write to an arithmetic model and reports such a slip at the first affected byte. If the fetch pointer is wrong, the wrong glyph byte is expanded; this shows eight pixels later at the latest, and also directly in the request index. An error in the stride or the latched row skip shows at the first byte of the second row. Completion or restart errors show as a gap in the write strobe, a miscounted run length, or writes that appear after done.

// File: rtl/glyph_blit_pkg.sv
package glyph_blit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LOAD  = 2'd2,
        ST_WRITE = 2'd3
    } blit_state_e;

    // channel order is the write order within one pixel
    typedef enum logic [1:0] {
        CH_BLUE  = 2'd0,
        CH_GREEN = 2'd1,
        CH_RED   = 2'd2
    } chan_e;

    typedef struct packed {
        logic [7:0] red;
        logic [7:0] green;
        logic [7:0] blue;
    } rgb_t;

    localparam int BYTES_PER_PIXEL = 3;

    function automatic rgb_t expand_bit(input logic lit);
        rgb_t c;
        c.red   = lit ? 8'hFF : 8'h00;
        c.green = lit ? 8'hFF : 8'h00;
        c.blue  = lit ? 8'hFF : 8'h00;
        return c;
    endfunction

    function automatic logic [7:0] pick_channel(input rgb_t c, input chan_e ch);
        logic [7:0] v;
        case (ch)
            CH_BLUE:  v = c.blue;
            CH_GREEN: v = c.green;
            default:  v = c.red;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/glyph_seq.sv
module glyph_seq
    import glyph_blit_pkg::*;
#(
    parameter int COLS  = 16,
    parameter int ROWS  = 29,
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic [PTR_W-1:0] rd_addr,
    output logic             accept,
    output logic             wr_en,
    output logic             pix_bit,
    output chan_e            chan,
    output logic             row_end,
    output logic             done
);
    localparam int COL_W = $clog2(COLS);
    localparam int ROW_W = $clog2(ROWS);

    blit_state_e      state_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    chan_e            ch_q;
    logic [PTR_W-1:0] ptr_q;
    logic [7:0]       sr_q;
    logic             done_q;

    logic in_write, last_ch, byte_end, last_col, last_row, final_wr, prefetch;

    always_comb begin
        in_write = (state_q == ST_WRITE);
        last_ch  = (ch_q == CH_RED);
        byte_end = (col_q[2:0] == 3'd7);
        last_col = (col_q == COL_W'(COLS - 1));
        last_row = (row_q == ROW_W'(ROWS - 1));
        final_wr = in_write && last_ch && last_col && last_row;
        // fetch the next byte one write ahead so its data lands on the byte edge
        prefetch = in_write && (ch_q == CH_GREEN) && byte_end && !(last_col && last_row);
        accept   = (state_q == ST_IDLE) && start;
        rd_valid = (state_q == ST_FETCH) || prefetch;
        rd_addr  = ptr_q;
        wr_en    = in_write;
        pix_bit  = sr_q[7];
        chan     = ch_q;
        row_end  = in_write && last_ch && last_col;
        done     = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            col_q   <= '0;
            row_q   <= '0;
            ch_q    <= CH_BLUE;
            ptr_q   <= '0;
            sr_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= final_wr;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_FETCH;
                        ptr_q   <= '0;
                        col_q   <= '0;
                        row_q   <= '0;
                        ch_q    <= CH_BLUE;
                    end
                end
                ST_FETCH: begin
                    ptr_q   <= ptr_q + 1'b1;
                    state_q <= ST_LOAD;
                end
                ST_LOAD: begin
                    sr_q    <= rd_data;
                    state_q <= ST_WRITE;
                end
                default: begin
                    if (prefetch) begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                    if (last_ch) begin
                        ch_q <= CH_BLUE;
                        sr_q <= byte_end ? rd_data : {sr_q[6:0], 1'b0};
                        if (last_col) begin
                            col_q <= '0;
                            if (last_row) begin
                                state_q <= ST_IDLE;
                            end else begin
                                row_q <= row_q + 1'b1;
                            end
                        end else begin
                            col_q <= col_q + 1'b1;
                        end
                    end else begin
                        ch_q <= chan_e'(ch_q + 2'd1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/glyph_addr_gen.sv
module glyph_addr_gen
    import glyph_blit_pkg::*;
#(
    parameter int POS_W  = 11,
    parameter int ADDR_W = 24,
    parameter int COLS   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [POS_W-1:0]  pos_x,
    input  logic [POS_W-1:0]  pos_y,
    input  logic [POS_W-1:0]  width,
    input  logic              step,
    input  logic              row_end,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q, skip_q;
    logic [ADDR_W-1:0] start_addr, row_skip;

    always_comb begin
        start_addr = base + (ADDR_W'(pos_x) + ADDR_W'(pos_y) * ADDR_W'(width))
                          * ADDR_W'(BYTES_PER_PIXEL);
        // jump from last byte of a row to first byte of the next
        row_skip   = (ADDR_W'(width) - ADDR_W'(COLS)) * ADDR_W'(BYTES_PER_PIXEL)
                   + ADDR_W'(1);
        addr       = addr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            skip_q <= '0;
        end else if (load) begin
            addr_q <= start_addr;
            skip_q <= row_skip;
        end else if (step) begin
            addr_q <= addr_q + (row_end ? skip_q : ADDR_W'(1));
        end
    end

endmodule

// File: rtl/glyph_blit.sv
module glyph_blit
    import glyph_blit_pkg::*;
#(
    parameter int  GLYPH_COLS = 16,
    parameter int  GLYPH_ROWS = 29,
    parameter int  POS_W      = 11,
    parameter int  ADDR_W     = 24,
    localparam int PTR_W      = $clog2(GLYPH_COLS / 8 * GLYPH_ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] fb_base,
    input  logic [POS_W-1:0]  pos_x,
    input  logic [POS_W-1:0]  pos_y,
    input  logic [POS_W-1:0]  fb_width,
    output logic              rd_valid,
    output logic [PTR_W-1:0]  rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done
);
    logic  accept, pix_bit, row_end;
    chan_e chan;

    glyph_seq #(
        .COLS (GLYPH_COLS),
        .ROWS (GLYPH_ROWS),
        .PTR_W(PTR_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .rd_data (rd_data),
        .rd_valid(rd_valid),
        .rd_addr (rd_addr),
        .accept  (accept),
        .wr_en   (wr_en),
        .pix_bit (pix_bit),
        .chan    (chan),
        .row_end (row_end),
        .done    (done)
    );

    glyph_addr_gen #(
        .POS_W (POS_W),
        .ADDR_W(ADDR_W),
        .COLS  (GLYPH_COLS)
    ) u_addr (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .base   (fb_base),
        .pos_x  (pos_x),
        .pos_y  (pos_y),
        .width  (fb_width),
        .step   (wr_en),
        .row_end(row_end),
        .addr   (wr_addr)
    );

    always_comb begin
        wr_data = pick_channel(expand_bit(pix_bit), chan);
    end

endmodule

// File: rtl/glyph_blit_chk.sv
module glyph_blit_chk #(
    parameter int ADDR_W = 24,
    parameter int PTR_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_valid,
    input logic [PTR_W-1:0]  rd_addr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              done
);
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!wr_en && $past(wr_en)));

    // R8
    wr_run_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_en) |-> done);

    // R4
    data_level_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_data == 8'hFF || wr_data == 8'h00));

    // R2
    fetch_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R2
    fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(wr_en)) |-> (rd_addr != '0));

    // R5
    addr_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_addr != $past(wr_addr)));

endmodule

bind glyph_blit glyph_blit_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_valid(rd_valid),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .done    (done)
);

// File: tb/glyph_blit_bench.sv
module glyph_blit_bench;
    localparam int COLS = 16;
    localparam int ROWS = 29;
    localparam int AW   = 24;
    localparam int PW   = 11;
    localparam int PTRW = $clog2(COLS / 8 * ROWS);
    localparam int NB   = COLS / 8 * ROWS;
    localparam int NW   = COLS * ROWS * 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [AW-1:0]   fb_base = '0;
    logic [PW-1:0]   pos_x = '0, pos_y = '0, fb_width = 11'd16;
    logic            rd_valid;
    logic [PTRW-1:0] rd_addr;
    logic [7:0]      rd_data = '0;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [7:0]      wr_data;
    logic            done;

    logic [7:0] mem [NB];

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    glyph_blit #(.GLYPH_COLS(COLS), .GLYPH_ROWS(ROWS), .POS_W(PW), .ADDR_W(AW)) u_glyph_blit (
        .clk(clk), .rst(rst), .start(start), .fb_base(fb_base), .pos_x(pos_x),
        .pos_y(pos_y), .fb_width(fb_width), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );

    // glyph store with one cycle of read latency
    always @(posedge clk) begin
        if (rd_valid) rd_data <= mem[int'(rd_addr) % NB];
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            miscompares++;
            $display("FAIL R8 watchdog expired: actual %0d cycles expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input longint base, input int x, input int y, input int w,
                       input int pat, input bit disturb);
        longint first;
        int c, k, f;
        bit seen;
        for (int i = 0; i < NB; i++) begin
            case (pat)
                0:       mem[i] = (i % 2 == 0) ? 8'hA5 : 8'h3C;
                1:       mem[i] = 8'hFF;
                2:       mem[i] = 8'h00;
                default: mem[i] = 8'((i * 37 + 5) ^ (i << 3));
            endcase
        end
        first = base + (x + y * w) * 3;
        @(negedge clk);
        fb_base = AW'(base); pos_x = PW'(x); pos_y = PW'(y); fb_width = PW'(w);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c = 1; k = 0; f = 0; seen = 1'b0;
        while (!seen && c < 3000) begin
            if (rd_valid) begin
                chk(int'(rd_addr) == f, "R2", "fetch index", rd_addr, f);
                f++;
            end
            if (c < 3) chk(!wr_en, "R8", "early write", wr_en, 0);
            if (wr_en) begin
                int p, ph, row, col;
                bit lit;
                longint ea;
                string rq;
                p = k / 3; ph = k % 3; row = p / COLS; col = p % COLS;
                lit = mem[row * (COLS / 8) + col / 8][7 - col % 8];
                ea = (first + row * w * 3 + col * 3 + ph) & ((64'd1 << AW) - 1);
                if (disturb && c > 200) rq = "R11";
                else if (k == 0) rq = "R6";
                else if (col == 0 && ph == 0) rq = "R7";
                else rq = "R5";
                chk(longint'(wr_addr) == ea, rq, "write address", wr_addr, ea);
                chk(wr_data == (lit ? 8'hFF : 8'h00), (pat == 1 || pat == 2) ? "R4" : "R3",
                    "write data", wr_data, lit ? 8'hFF : 8'h00);
                chk(c == k + 3, "R8", "write cycle", c, k + 3);
                k++;
            end
            if (done) begin
                seen = 1'b1;
                chk(c == NW + 3, "R9", "done cycle", c, NW + 3);
                chk(k == NW, "R8", "write count", k, NW);
                chk(f == NB, "R2", "fetch count", f, NB);
            end
            if (disturb && c == 200) begin
                start = 1'b1; fb_base = AW'(base + 999); fb_width = PW'(w + 7);
                pos_x = PW'(x + 5); pos_y = PW'(y + 3);
            end
            if (disturb && c == 201) start = 1'b0;
            @(negedge clk);
            c++;
        end
        chk(seen, "R9", "done seen", seen, 1);
        chk(!done, "R9", "done width", done, 0);
        for (int j = 0; j < 6; j++) begin
            chk(!wr_en && !rd_valid, "R10", "activity after done", {wr_en, rd_valid}, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!wr_en && !rd_valid && !done, "R1", "outputs in reset", {wr_en, rd_valid, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!wr_en && !rd_valid && !done, "R1", "outputs after reset", {wr_en, rd_valid, done}, 0);
        run(0, 0, 0, 16, 0, 1'b0);
        run(100, 3, 2, 40, 3, 1'b0);
        run(64'h1000, 17, 5, 64, 1, 1'b1);
        run(64'h20, 0, 1, 16, 2, 1'b0);
        run(64'h0ABC00, 1000, 700, 1920, 3, 1'b1);
        run(7, 31, 9, 33, 0, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule